// File: doc/BRIEF.md
# DDR ADC Sample Deinterleaver

This block sits right after the input pins of a 16-bit converter. The converter sends each sample over a narrow source-synchronous bus at double data rate. On every cycle of the converter's data clock, one half of the sample's bits is sampled on the rising edge and the other half on the falling edge. The rising half carries the odd bit positions and the falling half carries the even ones. The block captures both halves, holds the rising half until the falling half has arrived, and interleaves them into one full-width sample. A static control bit exchanges the roles of the two halves. Software sets it when board timing makes the capture phase come out reversed.

Samples flow only after software issues a start strobe. A capture then runs for a fixed number of samples. Each reconstructed sample is offered on a valid/ready output for exactly one cycle and is never held back. If the consumer is not ready, that sample is lost and a sticky overflow flag is raised. The converter's over-range signal travels with each sample. It also sets a sticky over-range flag when it is seen inside a capture. Software clears each sticky flag by pulsing its clear input.

Top module: `adc_ddr_deinterleave`

## Requirements
- R1: With `edge_swap` low, lane i sampled on the rising edge becomes sample bit 2i+1, and lane i sampled on the falling edge of the same cycle becomes sample bit 2i, for every i.
- R2: With `edge_swap` high, lane i of the rising edge becomes bit 2i and lane i of the falling edge becomes bit 2i+1.
- R3: No valid sample is produced unless a `cap_start` pulse has begun a capture. Lane activity and `ovr_in` while idle have no effect on any output.
- R4: A `cap_start` sampled at clock edge S starts a capture. It accepts the rising halves at edges S+1 to S+CAPTURE_LEN. The sample whose rising half is taken at edge N is presented with `out_valid` high from edge N+1, for one cycle. A capture therefore yields exactly CAPTURE_LEN valid samples in consecutive cycles, in arrival order.
- R5: A `cap_start` pulse that arrives while a capture is running is ignored. It neither restarts nor extends the capture.
- R6: `sticky_ovf` sets on the edge after a cycle with `out_valid` high and `out_ready` low. It stays set until a pulse on `ovf_clr`. It never sets while `out_ready` stays high.
- R7: `sticky_ovr` sets after a captured sample carries a high `ovr_in`. It stays set until a pulse on `ovr_clr`. A high `ovr_in` outside a capture does not set it.
- R8: `out_ovr` is the level of `ovr_in` sampled at the rising edge that took the same sample's rising half. It travels aligned with `out_data`.
- R9: After reset, `out_valid`, `out_ovr`, `sticky_ovf` and `sticky_ovr` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter data clock; both edges carry data |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_in | input | LANES | DDR data lanes |
| ovr_in | input | 1 | Converter over-range indication, sampled with the rising half |
| edge_swap | input | 1 | Exchange the odd/even roles of the two edge halves |
| cap_start | input | 1 | One-cycle capture start strobe |
| ovf_clr | input | 1 | Clear pulse for the sticky overflow flag |
| ovr_clr | input | 1 | Clear pulse for the sticky over-range flag |
| out_data | output | 2*LANES | Reconstructed sample |
| out_ovr | output | 1 | Over-range bit belonging to `out_data` |
| out_valid | output | 1 | One-cycle strobe per reconstructed sample |
| out_ready | input | 1 | Consumer accepts the sample this cycle |
| sticky_ovf | output | 1 | Sticky overflow status |
| sticky_ovr | output | 1 | Sticky over-range status |

## Verification
The merge is driven with walking single ones, which pin each lane and edge to one bit position. It is also driven with the alternating 0xAAAA/0x5555 words, which separate the odd and even halves and so expose a missing or unwanted swap. Mixed pseudo-random words catch cross-lane mixing. These patterns run in both swap settings, and each output is compared with the sample the bench intended to send. Captures without a start, with a second start mid-run, with the consumer stalled, and with over-range raised inside and outside a window check the sample count, the per-sample over-range bit and the sticky flags, together with their clearing.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

   typedef enum logic {
      CAP_IDLE = 1'b0,
      CAP_RUN  = 1'b1
   } cap_state_e;

   // Bit count of a counter able to hold the value n
   function automatic int cnt_bits(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/ddr_half_capture.sv
module ddr_half_capture #(
   parameter int LANES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] lane_in,
   input  logic             ovr_in,
   output logic [LANES-1:0] rise_q,
   output logic [LANES-1:0] fall_q,
   output logic             ovr_q
);

   initial begin
      if (LANES < 1) $error("ddr_half_capture: LANES must be at least 1");
   end

   // Rising half and its over-range flag are held for a full cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_q <= '0;
         ovr_q  <= 1'b0;
      end else begin
         rise_q <= lane_in;
         ovr_q  <= ovr_in;
      end
   end

   // Falling half arrives half a cycle later, ready for the next rising edge
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) fall_q <= '0;
      else        fall_q <= lane_in;
   end

endmodule

// File: rtl/lane_merge.sv
module lane_merge #(
   parameter int LANES    = 8,
   parameter bit HAS_SWAP = 1'b1,
   localparam int SW      = 2 * LANES
) (
   input  logic [LANES-1:0] rise_half,
   input  logic [LANES-1:0] fall_half,
   input  logic             swap,
   output logic [SW-1:0]    sample
);

   initial begin
      if (LANES < 1) $error("lane_merge: LANES must be at least 1");
   end

   logic [LANES-1:0] odd_src;
   logic [LANES-1:0] even_src;

   generate
      if (HAS_SWAP) begin : g_swap
         assign odd_src  = swap ? fall_half : rise_half;
         assign even_src = swap ? rise_half : fall_half;
      end else begin : g_fixed
         logic unused_swap;
         assign unused_swap = swap;
         assign odd_src     = rise_half;
         assign even_src    = fall_half;
      end
   endgenerate

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_bit
         assign sample[2*i+1] = odd_src[i];
         assign sample[2*i]   = even_src[i];
      end
   endgenerate

endmodule

// File: rtl/capture_ctrl.sv
module capture_ctrl
   import adc_cap_pkg::*;
#(
   parameter int CAPTURE_LEN = 16,
   localparam int CW         = cnt_bits(CAPTURE_LEN)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cap_start,
   output logic run
);

   initial begin
      if (CAPTURE_LEN < 1) $error("capture_ctrl: CAPTURE_LEN must be at least 1");
   end

   localparam logic [CW-1:0] LAST = CW'(CAPTURE_LEN - 1);

   cap_state_e    state;
   logic [CW-1:0] taken;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= CAP_IDLE;
         taken <= '0;
      end else begin
         unique case (state)
            CAP_IDLE: begin
               if (cap_start) begin
                  state <= CAP_RUN;
                  taken <= '0;
               end
            end
            CAP_RUN: begin
               if (taken == LAST) begin
                  state <= CAP_IDLE;
                  taken <= '0;
               end else begin
                  taken <= taken + 1'b1;
               end
            end
            default: state <= CAP_IDLE;
         endcase
      end
   end

   assign run = (state == CAP_RUN);

   assert_start_needed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> $past(cap_start));

   assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      taken <= LAST);

   assert_no_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && taken != '0) |-> (taken == $past(taken) + 1'b1));

endmodule

// File: rtl/status_sticky.sv
module status_sticky #(
   parameter int NFLAGS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NFLAGS-1:0] set,
   input  logic [NFLAGS-1:0] clr,
   output logic [NFLAGS-1:0] flag
);

   initial begin
      if (NFLAGS < 1) $error("status_sticky: NFLAGS must be at least 1");
   end

   generate
      for (genvar b = 0; b < NFLAGS; b++) begin : g_flag
         // A set in the same cycle as a clear wins, so no event is lost
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      flag[b] <= 1'b0;
            else if (set[b]) flag[b] <= 1'b1;
            else if (clr[b]) flag[b] <= 1'b0;
         end

         assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[b] && !clr[b]) |=> flag[b]);
      end
   endgenerate

endmodule

// File: rtl/adc_ddr_deinterleave.sv
module adc_ddr_deinterleave #(
   parameter int LANES       = 8,
   parameter int CAPTURE_LEN = 16,
   parameter bit HAS_SWAP    = 1'b1,
   localparam int SW         = 2 * LANES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] lane_in,
   input  logic             ovr_in,
   input  logic             edge_swap,
   input  logic             cap_start,
   input  logic             ovf_clr,
   input  logic             ovr_clr,
   output logic [SW-1:0]    out_data,
   output logic             out_ovr,
   output logic             out_valid,
   input  logic             out_ready,
   output logic             sticky_ovf,
   output logic             sticky_ovr
);

   initial begin
      if (LANES < 1)       $error("adc_ddr_deinterleave: LANES must be at least 1");
      if (CAPTURE_LEN < 1) $error("adc_ddr_deinterleave: CAPTURE_LEN must be at least 1");
   end

   localparam int F_OVF = 0;
   localparam int F_OVR = 1;

   logic [LANES-1:0] rise_q;
   logic [LANES-1:0] fall_q;
   logic             ovr_q;
   logic [SW-1:0]    merged;
   logic             run;
   logic             pend_q;
   logic [1:0]       flag_set;
   logic [1:0]       flag_clr;
   logic [1:0]       flags;

   ddr_half_capture #(.LANES(LANES)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .lane_in (lane_in),
      .ovr_in  (ovr_in),
      .rise_q  (rise_q),
      .fall_q  (fall_q),
      .ovr_q   (ovr_q)
   );

   lane_merge #(.LANES(LANES), .HAS_SWAP(HAS_SWAP)) u_merge (
      .rise_half (rise_q),
      .fall_half (fall_q),
      .swap      (edge_swap),
      .sample    (merged)
   );

   capture_ctrl #(.CAPTURE_LEN(CAPTURE_LEN)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_start (cap_start),
      .run       (run)
   );

   // pend_q marks that the rising half in rise_q belongs to the capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q    <= 1'b0;
         out_valid <= 1'b0;
         out_ovr   <= 1'b0;
         out_data  <= '0;
      end else begin
         pend_q    <= run;
         out_valid <= pend_q;
         if (pend_q) begin
            out_data <= merged;
            out_ovr  <= ovr_q;
         end else begin
            out_ovr  <= 1'b0;
         end
      end
   end

   assign flag_set[F_OVF] = out_valid && !out_ready;
   assign flag_set[F_OVR] = out_valid && out_ovr;
   assign flag_clr[F_OVF] = ovf_clr;
   assign flag_clr[F_OVR] = ovr_clr;

   status_sticky #(.NFLAGS(2)) u_status (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (flag_set),
      .clr   (flag_clr),
      .flag  (flags)
   );

   assign sticky_ovf = flags[F_OVF];
   assign sticky_ovr = flags[F_OVR];

   assert_valid_in_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(run, 2));

   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> sticky_ovf);

   assert_overrange_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ovr) |=> sticky_ovr);

   assert_ovr_only_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_ovr |-> out_valid);

endmodule

// File: tb/tb_adc_ddr_deinterleave.sv
module tb_adc_ddr_deinterleave;

   localparam int LANES = 8;
   localparam int LEN   = 16;
   localparam int SW    = 2 * LANES;
   localparam int NPAT  = LEN + 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [LANES-1:0] lane_in = '0;
   logic             ovr_in = 1'b0;
   logic             edge_swap = 1'b0;
   logic             cap_start = 1'b0;
   logic             ovf_clr = 1'b0;
   logic             ovr_clr = 1'b0;
   logic             out_ready = 1'b1;
   logic [SW-1:0]    out_data;
   logic             out_ovr;
   logic             out_valid;
   logic             sticky_ovf;
   logic             sticky_ovr;

   int checks = 0;
   int errors = 0;
   int seen_valid = 0;
   bit finished = 1'b0;
   string cur_req = "R1";

   logic [SW-1:0] pat [NPAT];
   logic          pat_ovr [NPAT];
   logic [SW-1:0] exp_q [$];
   logic          exp_ovr_q [$];

   always #2.5 clk = ~clk;

   adc_ddr_deinterleave #(.LANES(LANES), .CAPTURE_LEN(LEN)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .lane_in    (lane_in),
      .ovr_in     (ovr_in),
      .edge_swap  (edge_swap),
      .cap_start  (cap_start),
      .ovf_clr    (ovf_clr),
      .ovr_clr    (ovr_clr),
      .out_data   (out_data),
      .out_ovr    (out_ovr),
      .out_valid  (out_valid),
      .out_ready  (out_ready),
      .sticky_ovf (sticky_ovf),
      .sticky_ovr (sticky_ovr)
   );

   task automatic check(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Output monitor, sampled on the falling edge where outputs are settled
   always @(negedge clk) begin
      if (rst_n && out_valid && !finished) begin
         seen_valid++;
         if (exp_q.size() == 0) begin
            check(cur_req, "unexpected valid sample", 1, 0);
         end else begin
            logic [SW-1:0] e;
            logic          eo;
            e  = exp_q.pop_front();
            eo = exp_ovr_q.pop_front();
            if (out_ready) begin
               check(cur_req, "sample data", out_data, e);
               check("R8", "sample over-range bit", out_ovr, eo);
            end
         end
      end
   end

   // Rising lane i carries the odd bit 2i+1 unless swapped
   function automatic logic [LANES-1:0] rise_of(input logic [SW-1:0] s, input logic sw);
      logic [LANES-1:0] r;
      for (int i = 0; i < LANES; i++) r[i] = sw ? s[2*i] : s[2*i+1];
      return r;
   endfunction

   function automatic logic [LANES-1:0] fall_of(input logic [SW-1:0] s, input logic sw);
      logic [LANES-1:0] f;
      for (int i = 0; i < LANES; i++) f[i] = sw ? s[2*i+1] : s[2*i];
      return f;
   endfunction

   // Entered just after a falling edge; leaves just after a falling edge
   task automatic drive_capture(input bit give_start, input int mid_start_at);
      seen_valid = 0;
      cap_start  = give_start;
      lane_in    = 8'h3c;
      @(posedge clk); #1;
      cap_start = 1'b0;
      lane_in   = 8'hc3;
      @(negedge clk); #1;
      for (int k = 0; k < NPAT; k++) begin
         lane_in = rise_of(pat[k], edge_swap);
         ovr_in  = pat_ovr[k];
         if (give_start && k < LEN) begin
            exp_q.push_back(pat[k]);
            exp_ovr_q.push_back(pat_ovr[k]);
         end
         if (k == mid_start_at) cap_start = 1'b1;
         @(posedge clk); #1;
         cap_start = 1'b0;
         lane_in   = fall_of(pat[k], edge_swap);
         @(negedge clk); #1;
      end
      lane_in = '0;
      ovr_in  = 1'b0;
      repeat (3) begin
         @(negedge clk); #1;
      end
      check(cur_req, "valid sample count", seen_valid, give_start ? LEN : 0);
      check(cur_req, "samples left undelivered", exp_q.size(), 0);
      exp_q.delete();
      exp_ovr_q.delete();
   endtask

   task automatic clear_pulse(input bit ovf, input bit ovr);
      ovf_clr = ovf;
      ovr_clr = ovr;
      @(posedge clk); #1;
      ovf_clr = 1'b0;
      ovr_clr = 1'b0;
      @(negedge clk); #1;
   endtask

   task automatic fill_walk_and_alt();
      for (int k = 0; k < NPAT; k++) begin
         pat_ovr[k] = 1'b0;
         if (k < SW) pat[k] = SW'(1) << k;
         else        pat[k] = (k % 2 == 0) ? 16'haaaa : 16'h5555;
      end
      pat[1] = 16'haaaa;
      pat[2] = 16'h5555;
   endtask

   task automatic fill_mixed(input logic [SW-1:0] seed);
      logic [SW-1:0] v;
      v = seed;
      for (int k = 0; k < NPAT; k++) begin
         v = {v[SW-2:0], v[SW-1] ^ v[SW-3] ^ v[SW-4] ^ v[SW-6]};
         pat[k]     = v ^ SW'(k * 16'h1357);
         pat_ovr[k] = 1'b0;
      end
   endtask

   task automatic t_reset_state();
      cur_req = "R9";
      check("R9", "out_valid after reset", out_valid, 0);
      check("R9", "out_ovr after reset", out_ovr, 0);
      check("R9", "sticky_ovf after reset", sticky_ovf, 0);
      check("R9", "sticky_ovr after reset", sticky_ovr, 0);
   endtask

   task automatic t_merge_plain();
      cur_req   = "R1";
      edge_swap = 1'b0;
      fill_walk_and_alt();
      drive_capture(1'b1, -1);   // R4 count checked inside
      fill_mixed(16'hace1);
      drive_capture(1'b1, -1);
   endtask

   task automatic t_merge_swap();
      cur_req   = "R2";
      edge_swap = 1'b1;
      fill_walk_and_alt();
      drive_capture(1'b1, -1);
      fill_mixed(16'h1d2b);
      drive_capture(1'b1, -1);
      edge_swap = 1'b0;
   endtask

   task automatic t_no_start();
      cur_req = "R3";
      fill_mixed(16'h7777);
      for (int k = 0; k < NPAT; k++) pat_ovr[k] = 1'b1;
      drive_capture(1'b0, -1);
      check("R3", "idle over-range leaves sticky_ovr", sticky_ovr, 0);
      check("R3", "idle leaves sticky_ovf", sticky_ovf, 0);
   endtask

   task automatic t_restart_ignored();
      cur_req = "R5";
      fill_mixed(16'h0f0f);
      drive_capture(1'b1, 5);
   endtask

   task automatic t_overflow();
      cur_req = "R6";
      check("R6", "no overflow while ready stayed high", sticky_ovf, 0);
      out_ready = 1'b0;
      fill_mixed(16'hbeef);
      drive_capture(1'b1, -1);
      out_ready = 1'b1;
      check("R6", "overflow set by stalled consumer", sticky_ovf, 1);
      repeat (4) @(negedge clk);
      #1;
      check("R6", "overflow stays set", sticky_ovf, 1);
      clear_pulse(1'b0, 1'b1);
      check("R6", "other clear leaves overflow", sticky_ovf, 1);
      clear_pulse(1'b1, 1'b0);
      check("R6", "overflow cleared by write", sticky_ovf, 0);
   endtask

   task automatic t_overrange();
      cur_req = "R7";
      fill_mixed(16'h4242);
      pat_ovr[6] = 1'b1;
      pat_ovr[LEN + 1] = 1'b1;   // outside the window, must not matter
      drive_capture(1'b1, -1);
      check("R7", "over-range set by captured sample", sticky_ovr, 1);
      repeat (3) @(negedge clk);
      #1;
      check("R7", "over-range stays set", sticky_ovr, 1);
      clear_pulse(1'b0, 1'b1);
      check("R7", "over-range cleared by write", sticky_ovr, 0);
      fill_mixed(16'h4243);
      pat_ovr[LEN] = 1'b1;
      drive_capture(1'b1, -1);
      check("R7", "over-range after window ignored", sticky_ovr, 0);
   endtask

   initial begin : watchdog
      #(200000 * 5);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk); #1;
      t_reset_state();
      t_merge_plain();
      t_merge_swap();
      t_no_start();
      t_restart_ignored();
      t_overflow();
      t_overrange();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule